// File: doc/BRIEF.md
# Single-Clock Queue with Same-Cycle Read Bypass

This block is a first-in first-out queue for one clock domain. Entries are held in a power-of-two row array (16 rows of 8 bits by default). Producers offer words on a valid/ready input. A consumer requests words with a plain pop strobe, and each accepted pop loads the head word into a registered read-data output. That output keeps its value until the next accepted pop.

The read row and the write row can be the same in a given cycle. This happens when the queue is empty and a word is accepted on the same edge as a pop. In that case the read register captures the incoming word instead of the stale row contents. A word can therefore reach the read output on the edge it is accepted, one cycle after it was offered, rather than two cycles later.

Back-pressure rules: `in_ready` is high exactly when the queue is not full. A word transfers on an edge where both `in_valid` and `in_ready` are high. While `in_ready` is low, an offered word is not taken, and the producer must hold it until `in_ready` returns. A pop is accepted when the queue holds a word, or when a word is accepted on the same edge. Any other pop has no effect.

Top module: `rowq_fifo`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), `empty`=1, `full`=0, `count`=0, `in_ready`=1 and `rd_data`=0.
- R2: Words leave through `rd_data` in the order they were accepted. `rd_data` changes on the edge where the pop is accepted.
- R3: While `full`=1, `in_ready`=0 and an offered word is dropped. `count` does not rise, and stored words are not overwritten.
- R4: A pop while `empty`=1 with no word accepted on the same edge is ignored. `count` stays 0 and `rd_data` keeps its value.
- R5: On an edge without an accepted pop, `rd_data` holds its previous value.
- R6: If a word is accepted and a pop is requested on the same edge while `empty`=1, `rd_data` takes that word on that edge and `count` stays 0.
- R7: `count` equals accepted words minus accepted pops. `empty` is high exactly when `count`=0, and `full` is high exactly when `count`=16.
- R8: An accepted word and an accepted pop on the same edge while the queue holds 1 to 15 words leave `count` unchanged.
- R9: Read and write positions wrap modulo the depth, so ordering holds across any number of words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Queue can take a word (not full) |
| in_data | input | 8 | Input word |
| pop | input | 1 | Request to move the head word to `rd_data` |
| rd_data | output | 8 | Registered read data |
| full | output | 1 | Queue holds 16 words |
| empty | output | 1 | Queue holds no words |
| count | output | 5 | Number of stored words |

## Verification
The bypass case can only be reached from an empty queue with a push and a pop offered on the same edge. The mirror case is a rejected push at full combined with a pop that is accepted. Neither occurs in ordinary streaming traffic.

The bench therefore resets the queue and fills it to every level from 0 to 16. At each level it applies each of the four push/pop combinations, then drains the queue and compares every word against an arithmetic model. A long mixed-traffic run then takes the positions through several wraps.

// File: rtl/rowq_pkg.sv
package rowq_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUT  = 2'b01,
    OP_TAKE = 2'b10,
    OP_BOTH = 2'b11
  } rowq_op_e;

  function automatic rowq_op_e rowq_decode(input logic put, input logic take);
    return rowq_op_e'({take, put});
  endfunction
endpackage

// File: rtl/rowq_ptr.sv
module rowq_ptr #(
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inc,
  output logic [AW:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (inc) ptr <= ptr + 1'b1;
  end

  assert_step_R9: assert property (@(posedge clk) disable iff (rst)
    inc |=> ptr == $past(ptr) + 1'b1);
  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(ptr));
endmodule

// File: rtl/rowq_store.sv
module rowq_store #(
  parameter int W  = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rq
);
  localparam int ROWS = 1 << AW;

  logic [W-1:0] rows [ROWS];
  logic         same_row;

  assign same_row = we && (wa == ra);

  always_ff @(posedge clk) begin
    if (we) rows[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rst) rq <= '0;
    else if (re) rq <= same_row ? wd : rows[ra];
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rq));
  assert_bypass_R6: assert property (@(posedge clk) disable iff (rst)
    (re && we && wa == ra) |=> rq == $past(wd));
endmodule

// File: rtl/rowq_fifo.sv
module rowq_fifo #(
  parameter int W  = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  input  logic          pop,
  output logic [W-1:0]  rd_data,
  output logic          full,
  output logic          empty,
  output logic [AW:0]   count
);
  import rowq_pkg::*;

  localparam int DEPTH = 1 << AW;

  logic [AW:0] wr_ptr, rd_ptr;
  logic        put_ok, take_ok;
  rowq_op_e    op;

  assign empty    = (wr_ptr == rd_ptr);
  assign full     = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign count    = wr_ptr - rd_ptr;
  assign in_ready = !full;
  assign put_ok   = in_valid && !full;
  assign take_ok  = pop && (!empty || put_ok);
  assign op       = rowq_decode(put_ok, take_ok);

  rowq_ptr #(.AW(AW)) wr_ptr_i (.clk(clk), .rst(rst), .inc(put_ok),  .ptr(wr_ptr));
  rowq_ptr #(.AW(AW)) rd_ptr_i (.clk(clk), .rst(rst), .inc(take_ok), .ptr(rd_ptr));

  rowq_store #(.W(W), .AW(AW)) store_i (
    .clk(clk), .rst(rst),
    .we(put_ok), .wa(wr_ptr[AW-1:0]), .wd(in_data),
    .re(take_ok), .ra(rd_ptr[AW-1:0]), .rq(rd_data)
  );

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && full && !pop) |=> (full && $stable(count)));
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !in_valid) |=> (empty && $stable(rd_data)));
  assert_balanced_R8: assert property (@(posedge clk) disable iff (rst)
    (op == OP_BOTH) |=> $stable(count));
  assert_flags_R7: assert property (@(posedge clk) disable iff (rst)
    !(full && empty) && (count <= (AW+1)'(DEPTH)));
endmodule

// File: tb/rowq_fifo_tb_top.sv
`timescale 1ns/1ps
module rowq_fifo_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid, in_ready, pop, full, empty;
  logic [7:0] in_data, rd_data;
  logic [4:0] count;

  int vec = 0, bad = 0;
  bit finished = 0;

  logic [7:0] mq [16];
  int         mcnt, mhead;
  logic [7:0] mrd;

  always #2.5 clk = ~clk;

  rowq_fifo dut_i (.clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .pop(pop), .rd_data(rd_data), .full(full), .empty(empty),
    .count(count));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "rd_data", rd_data, mrd);
    chk("R7", "count", count, mcnt);
    chk("R7", "empty", empty, mcnt == 0);
    chk("R7", "full", full, mcnt == 16);
    chk("R3", "in_ready", in_ready, mcnt != 16);
  endtask

  task automatic do_reset();
    rst = 1; in_valid = 0; pop = 0; in_data = 0;
    @(posedge clk); @(posedge clk); #1;
    rst = 0;
    mcnt = 0; mhead = 0; mrd = 0;
    chk("R1", "rd_data", rd_data, 0);
    chk("R1", "count", count, 0);
    chk("R1", "empty", empty, 1);
    chk("R1", "full", full, 0);
    chk("R1", "in_ready", in_ready, 1);
  endtask

  task automatic step(input bit p, input logic [7:0] d, input bit q);
    string tag;
    bit ap, aq;
    if (p && mcnt == 16) tag = "R3";
    else if (q && !p && mcnt == 0) tag = "R4";
    else if (p && q && mcnt == 0) tag = "R6";
    else if (p && q) tag = "R8";
    else if (!q) tag = "R5";
    else tag = "R2";
    in_valid = p; in_data = d; pop = q;
    @(posedge clk); #1;
    ap = p && (mcnt < 16);
    aq = q && (mcnt > 0 || ap);
    if (aq && mcnt == 0) begin
      mrd = d;
    end else begin
      if (aq) begin
        mrd = mq[mhead]; mhead = (mhead + 1) % 16; mcnt--;
      end
      if (ap) begin
        mq[(mhead + mcnt) % 16] = d; mcnt++;
      end
    end
    in_valid = 0; pop = 0;
    check_all(tag);
  endtask

  initial begin
    do_reset();
    step(0, 8'h00, 1);            // R4 pop on empty
    step(1, 8'hA5, 1);            // R6 bypass
    chk("R6", "bypass word", rd_data, 8'hA5);
    step(0, 8'h00, 0);            // R5 hold
    for (int lvl = 0; lvl <= 16; lvl++) begin
      for (int op = 0; op < 4; op++) begin
        do_reset();
        for (int i = 0; i < lvl; i++) step(1, 8'((lvl * 16 + i) ^ 8'h5A), 0);
        step(0, 8'h00, 0);
        step(op[0], 8'(8'hC3 ^ lvl), op[1]);
        while (mcnt > 0) step(0, 8'h00, 1);   // R2 drain order
        step(0, 8'h00, 1);                     // R4 after drain
      end
    end
    do_reset();
    begin
      int s = 7;
      for (int k = 0; k < 600; k++) begin     // R9 wrap through many rows
        s = (s * 1103515245 + 12345) & 32'h7fffffff;
        step(s[16] | s[17], 8'(s >> 8), s[18] & (s[19] | s[20]));
      end
    end
    while (mcnt > 0) step(0, 8'h00, 1);
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule